// File: doc/BRIEF.md
# Fractional-Duty Dithering PWM Generator

This block is a fixed-period pulse width modulator whose duty command has finer resolution than one clock tick. The command holds a whole tick count in its upper field and an 8-bit fraction in its lower field. Any single switching period can only use a whole number of on-ticks. So at every period boundary the block picks one of the two whole counts next to the command. A first-order fractional accumulator makes the choice, so that over many periods the mean on-time equals the fractional command.

A period counter runs from 0 to PERIOD-1. The output is high for the first `cmp` cycles of each period, where `cmp` is the applied compare count. The period strobe is high in the last cycle of each period. On that same clock edge the block samples the duty input, adds the fraction to the accumulator and loads the new compare count, which applies to the period that follows. The applied count is clamped to PERIOD, which means fully on.

Top module: `dither_pwm`

## Requirements
- R1: During and after synchronous reset the output and the strobe are low. The compare count and the accumulator reset to zero, so the first period after reset has no on-cycles.
- R2: `periodStrobe` is high for exactly one cycle in every PERIOD cycles, in the last cycle of each period.
- R3: The duty input is sampled only in the cycle where `periodStrobe` is high. A change at any other time has no effect on the period in progress.
- R4: Within a period the output is high for exactly the applied count of cycles, starting at the first cycle of the period and all in one run.
- R5: With a fractional field of zero, every period uses the same count, equal to the integer field clamped to PERIOD.
- R6: Each period's count is either the integer field or the integer field plus one (both clamped to PERIOD). No other value occurs.
- R7: With a constant command and an integer field below PERIOD, any 256 consecutive periods contain exactly F periods at the upper count, where F is the fractional field `dutyCmd[7:0]`.
- R8: The applied count never exceeds PERIOD. An integer field of PERIOD or more, or PERIOD-1 with a carry, gives a fully-on period.
- R9: The accumulator adds F at each strobe and uses the upper count only on carry-out of its 8 bits. After reset with F=128, the first two latched periods use the integer count and then the integer count plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dutyCmd | input | CNT_W+FRAC_W | Duty command: `[CNT_W+FRAC_W-1:FRAC_W]` integer tick count, `[FRAC_W-1:0]` fraction |
| pwmOut | output | 1 | Modulated output |
| periodStrobe | output | 1 | High in the last cycle of each period |

## Verification
The period wrap and the duty load happen on the same edge. That edge can also produce an accumulator carry and a clamp to PERIOD. The bench drives integer fields of PERIOD-1 with a fraction of 255 and integer fields above PERIOD. In those cases the carry and the saturation meet on the load edge, and the bench checks that every period measures exactly PERIOD on-cycles or the lower neighbour. A mid-period command change is also placed just before the wrap, and the bench checks that only the next period sees it.

// File: rtl/dither_pwm_pkg.sv
package dither_pwm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic periodEnd;  // last cycle of a switching period
    logic loadDuty;   // sample command, advance accumulator, load compare
  } pwmStrobe_t;
endpackage

// File: rtl/dither_pwm_ctrl.sv
module dither_pwm_ctrl
  import dither_pwm_pkg::*;
#(
  parameter int PERIOD = 10,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strobes
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);

  logic atLast;
  assign atLast = (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (atLast) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_comb begin
    strobes.periodEnd = atLast && !rst;
    strobes.loadDuty  = atLast && !rst;
  end

  // R2
  strobe_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.periodEnd |=> (cnt == '0));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.periodEnd |=> !strobes.periodEnd);
endmodule

// File: rtl/dither_pwm_dp.sv
module dither_pwm_dp
  import dither_pwm_pkg::*;
#(
  parameter int PERIOD = 10,
  parameter int FRAC_W = 8,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W+FRAC_W-1:0] dutyCmd,
  input  logic [CNT_W-1:0]        cnt,
  input  pwmStrobe_t              strobes,
  output logic                    pwmOut
);
  localparam logic [CNT_W:0]   FULL_W = (CNT_W + 1)'(PERIOD);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(PERIOD);

  logic [CNT_W-1:0]  intPart;
  logic [FRAC_W-1:0] fracPart;
  logic [FRAC_W-1:0] accReg;
  logic [FRAC_W:0]   accSum;
  logic [CNT_W:0]    wantCnt;
  logic [CNT_W-1:0]  cmpNext;
  logic [CNT_W-1:0]  cmpReg;

  assign intPart  = dutyCmd[CNT_W+FRAC_W-1:FRAC_W];
  assign fracPart = dutyCmd[FRAC_W-1:0];

  always_comb begin
    accSum  = {1'b0, accReg} + {1'b0, fracPart};
    wantCnt = {1'b0, intPart} + {{CNT_W{1'b0}}, accSum[FRAC_W]};
    cmpNext = (wantCnt > FULL_W) ? FULL_C : wantCnt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg <= '0;
      cmpReg <= '0;
    end else if (strobes.loadDuty) begin
      accReg <= accSum[FRAC_W-1:0];
      cmpReg <= cmpNext;
    end
  end

  assign pwmOut = (cnt < cmpReg);

  // R8
  cmp_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cmpReg <= FULL_C);

  // R3
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadDuty |=> $stable(cmpReg));

  // R6
  cmp_neighbour_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadDuty |=>
      (({1'b0, cmpReg} == (({1'b0, $past(intPart)} > FULL_W) ? FULL_W : {1'b0, $past(intPart)})) ||
       ({1'b0, cmpReg} == (({1'b0, $past(intPart)} + 1'b1 > FULL_W) ? FULL_W : {1'b0, $past(intPart)} + 1'b1))));

  // R5
  cmp_const_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.loadDuty && (fracPart == '0)) |=>
      ({1'b0, cmpReg} == (({1'b0, $past(intPart)} > FULL_W) ? FULL_W : {1'b0, $past(intPart)})));
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dither_pwm_pkg::*;
#(
  parameter int PERIOD = 10,
  parameter int FRAC_W = 8,
  localparam int CNT_W = $clog2(PERIOD + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W+FRAC_W-1:0] dutyCmd,
  output logic                    pwmOut,
  output logic                    periodStrobe
);
  logic [CNT_W-1:0] cnt;
  pwmStrobe_t       strobes;

  dither_pwm_ctrl #(.PERIOD(PERIOD), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .cnt(cnt), .strobes(strobes)
  );

  dither_pwm_dp #(.PERIOD(PERIOD), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .dutyCmd(dutyCmd), .cnt(cnt),
    .strobes(strobes), .pwmOut(pwmOut)
  );

  assign periodStrobe = strobes.periodEnd;
endmodule

// File: tb/test_dither_pwm.sv
`timescale 1ns/1ps
module test_dither_pwm;
  localparam int PERIOD = 10;
  localparam int FRAC_W = 8;
  localparam int CNT_W  = $clog2(PERIOD + 1);
  localparam int NVEC   = 6;
  localparam int VEC_INT  [NVEC] = '{3, 5, 9, 10, 12, 0};
  localparam int VEC_FRAC [NVEC] = '{64, 0, 255, 77, 200, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W+FRAC_W-1:0] dutyCmd = '0;
  logic pwmOut, periodStrobe;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dither_pwm #(.PERIOD(PERIOD), .FRAC_W(FRAC_W)) i_dither_pwm (
    .clk(clk), .rst(rst), .dutyCmd(dutyCmd),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CNT_W+FRAC_W-1:0] mk(input int i, input int f);
    return {CNT_W'(i), FRAC_W'(f)};
  endfunction

  // Measure one period ending at the next strobe; must start right after a strobe.
  task automatic measure(output int highs, output int cyc, output bit contig);
    bit seenLow;
    highs = 0; cyc = 0; contig = 1'b1; seenLow = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      if (pwmOut) begin
        highs++;
        if (seenLow) contig = 1'b0;
      end else seenLow = 1'b1;
    end while (!periodStrobe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int h, c;
    bit ct;
    // R1 reset state
    dutyCmd = mk(4, 128);
    repeat (3) @(negedge clk);
    check(!pwmOut && !periodStrobe, "R1 outputs low in reset", int'(pwmOut), 0);
    @(negedge clk) rst = 1'b0;
    // first period: skip to strobe counting from here (cnt was 0 at release)
    h = 0;
    if (pwmOut) h++;
    while (!periodStrobe) begin
      @(negedge clk);
      if (pwmOut) h++;
    end
    check(h == 0, "R1 first period off", h, 0);
    // R9 accumulator from zero with F=128: 4, 5, 4
    measure(h, c, ct); check(h == 4, "R9 first latched period lower", h, 4);
    measure(h, c, ct); check(h == 5, "R9 second period upper on carry", h, 5);
    measure(h, c, ct); check(h == 4, "R9 third period lower", h, 4);
    check(c == PERIOD, "R2 strobe spacing", c, PERIOD);

    // R4 contiguous run from period start
    dutyCmd = mk(6, 0);
    measure(h, c, ct);
    measure(h, c, ct);
    check(h == 6, "R4 on-cycle count", h, 6);
    check(ct, "R4 single run at start", int'(ct), 1);

    // R3 mid-period change ignored by the running period
    dutyCmd = mk(2, 0);
    measure(h, c, ct);  // latches 2 at end
    h = 0;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge clk);
      if (pwmOut) h++;
      if (k == 2) dutyCmd = mk(8, 0);
      if (k == PERIOD - 3) dutyCmd = mk(7, 0);
    end
    check(periodStrobe, "R3 period alignment", int'(periodStrobe), 1);
    check(h == 2, "R3 running period unchanged", h, 2);
    measure(h, c, ct);
    check(h == 7, "R3 value present at strobe used", h, 7);

    // Vector table, 256-period windows
    for (int v = 0; v < NVEC; v++) begin
      int lo, hi, up, bad, badVal, cycBad;
      lo = (VEC_INT[v] > PERIOD) ? PERIOD : VEC_INT[v];
      hi = (VEC_INT[v] + 1 > PERIOD) ? PERIOD : VEC_INT[v] + 1;
      dutyCmd = mk(VEC_INT[v], VEC_FRAC[v]);
      measure(h, c, ct);  // period in which the new command is latched
      up = 0; bad = 0; badVal = 0; cycBad = 0;
      for (int p = 0; p < 256; p++) begin
        measure(h, c, ct);
        if (c != PERIOD) cycBad++;
        if (h == hi && hi != lo) up++;
        else if (h != lo) begin bad++; badVal = h; end
      end
      check(cycBad == 0, "R2 period length", cycBad, 0);
      check(bad == 0, "R6 only neighbour counts", badVal, lo);
      if (VEC_INT[v] >= PERIOD)
        check(bad == 0 && up == 0, "R8 clamp to fully on", up, 0);
      else if (VEC_FRAC[v] == 0)
        check(up == 0, "R5 constant count for zero fraction", up, 0);
      else if (VEC_INT[v] == PERIOD - 1)
        check(up == VEC_FRAC[v], "R8 upper neighbour equals PERIOD", up, VEC_FRAC[v]);
      else
        check(up == VEC_FRAC[v], "R7 upper-count periods in 256", up, VEC_FRAC[v]);
    end

    // R1 reset mid-run returns output low
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check(!pwmOut && !periodStrobe, "R1 reset mid-run", int'(pwmOut), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule